// File: doc/BRIEF.md
# Parallel-to-Serial Converter with Even Parity Insertion

This block takes a parallel word whose low seven bits carry a character code and whose top bit is a placeholder, and sends it out one bit per clock cycle, least significant bit first. The parity bit is not computed before shifting starts. A single D flip-flop folds each data bit into a running parity as that bit leaves the shift register. In the eighth slot an output multiplexer selects this running parity in place of the register's top bit. The eight transmitted bits therefore always hold an even number of ones.

The design is split into a datapath and a control unit. The datapath holds the shift register, the slot counter and the parity flip-flop. The control unit is a two-state machine that accepts a load strobe only while idle and runs the eight shift slots. The serial data, valid and done outputs leave the block through one register stage. Start and stop framing, bit-rate timing and a choice of parity sense belong to other blocks.

Top module: `p2s_parity_tx`

## Requirements
- R1: After a synchronous reset, `ser_o`, `ser_vld_o` and `done_o` are 0 and `ready_o` is 1.
- R2: A word on `word_i` is accepted at a clock edge where `load_i` and `ready_o` are both 1. `ready_o` is 0 in the following cycle. The first serial bit appears in the cycle after the next clock edge.
- R3: Word bits 0 to 6 are sent in ascending order, one per cycle, on `ser_o`.
- R4: The eighth serial bit is the XOR of word bits 0 to 6 (even parity over the eight sent bits). The value of input bit 7 has no effect on any serial bit.
- R5: `ser_vld_o` is 1 for exactly eight consecutive cycles per accepted word, and these are the cycles carrying the serial bits.
- R6: `done_o` is 1 for exactly one cycle, the cycle directly after the eighth valid bit. `ready_o` returns to 1 in the cycle in which the eighth bit is presented.
- R7: A `load_i` strobe while `ready_o` is 0 is ignored. The current word completes unchanged and no extra word follows it.
- R8: The parity state is cleared on each accepted word. A word loaded in the first ready cycle after a previous word gets its own correct parity bit, and its bits follow after one idle cycle.
- R9: `ser_o` is 0 in every cycle where `ser_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe, accepted only while `ready_o` is 1 |
| word_i | input | WORD_W (8) | Parallel word; bits 0..6 are data, bit 7 is a placeholder |
| ser_o | output | 1 | Serial data, least significant bit first |
| ser_vld_o | output | 1 | High while `ser_o` carries a bit of the word |
| done_o | output | 1 | One-cycle pulse after the eighth bit |
| ready_o | output | 1 | Converter idle, a load will be accepted |

## Verification
The hardest situation to reach from the ports is a load that lands in the one cycle where `ready_o` has just risen while the parity bit of the previous word is still on `ser_o`. Here the clear of the parity flip-flop for the new word coincides with the end of the old word. The stimulus chains words so that the next load is raised in exactly that cycle. It picks a previous word with odd data parity, so a missed clear would flip the next word's parity bit. A load strobe carrying a different word is also raised in the middle of a shift, and the bench confirms that the bits and the idle gap afterwards are unchanged. Random words with a random bit 7 are mixed with all-zero, all-one and single-bit directed patterns.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  // control unit states
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } p2s_state_e;
endpackage

// File: rtl/p2s_ctrl.sv
module p2s_ctrl
  import p2s_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic slot_last_i,
  output logic load_en_o,
  output logic shift_en_o,
  output logic idle_o
);
  p2s_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_en_o  = 1'b0;
    shift_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          load_en_o = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_en_o = 1'b1;
        if (slot_last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/p2s_slot_cnt.sv
module p2s_slot_cnt #(
  parameter int WORD_W = 8,
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= (cnt_q == LAST_SLOT) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_SLOT);
endmodule

// File: rtl/p2s_shifter.sv
module p2s_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              lsb_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)          sreg_q <= '0;
    else if (load_i)  sreg_q <= word_i;
    else if (shift_i) sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
  end

  assign lsb_o = sreg_q[0];
endmodule

// File: rtl/p2s_parity_ff.sv
module p2s_parity_ff (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic fold_i,
  input  logic bit_i,
  output logic par_o
);
  logic par_q;

  // D flip-flop: next = bit XOR present while folding
  always_ff @(posedge clk) begin
    if (rst || clear_i) par_q <= 1'b0;
    else if (fold_i)    par_q <= par_q ^ bit_i;
  end

  assign par_o = par_q;
endmodule

// File: rtl/p2s_parity_tx.sv
module p2s_parity_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              ser_vld_o,
  output logic              done_o,
  output logic              ready_o
);
  logic load_en, shift_en, idle, slot_last;
  logic lsb, par;
  logic ser_q, vld_q, tail_q, done_q;

  p2s_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .slot_last_i (slot_last),
    .load_en_o   (load_en),
    .shift_en_o  (shift_en),
    .idle_o      (idle)
  );

  p2s_slot_cnt #(.WORD_W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load_en),
    .step_i  (shift_en),
    .last_o  (slot_last)
  );

  p2s_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_en),
    .shift_i (shift_en),
    .word_i  (word_i),
    .lsb_o   (lsb)
  );

  p2s_parity_ff u_par (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load_en),
    .fold_i  (shift_en && !slot_last),
    .bit_i   (lsb),
    .par_o   (par)
  );

  // output stage: last slot takes the running parity instead of the top bit
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q  <= 1'b0;
      vld_q  <= 1'b0;
      tail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ser_q  <= shift_en ? (slot_last ? par : lsb) : 1'b0;
      vld_q  <= shift_en;
      tail_q <= shift_en && slot_last;
      done_q <= tail_q;
    end
  end

  assign ser_o     = ser_q;
  assign ser_vld_o = vld_q;
  assign done_o    = done_q;
  assign ready_o   = idle;
endmodule

// File: rtl/p2s_chk.sv
module p2s_chk #(
  parameter int WORD_W = 8
) (
  input logic clk,
  input logic rst,
  input logic load_i,
  input logic ser_o,
  input logic ser_vld_o,
  input logic done_o,
  input logic ready_o
);
  localparam int RUN_W = $clog2(WORD_W + 1) + 1;

  logic [RUN_W-1:0] run_q;
  logic             acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      acc_q <= 1'b0;
    end else if (ser_vld_o) begin
      run_q <= run_q + 1'b1;
      acc_q <= acc_q ^ ser_o;
    end else begin
      run_q <= '0;
      acc_q <= 1'b0;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) $past(rst) |-> (ready_o && !ser_vld_o && !done_o && !ser_o));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (ready_o && load_i) |=> !ready_o);
  // R4
  even_parity_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> !acc_q);
  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(ser_vld_o) |-> (run_q == RUN_W'(WORD_W)));
  // R6
  done_after_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> ($past(ser_vld_o) && !ser_vld_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
  // R7
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst) $rose(ser_vld_o) |-> $past(!ready_o));
  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst) !ser_vld_o |-> !ser_o);
endmodule

bind p2s_parity_tx p2s_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_i    (load_i),
  .ser_o     (ser_o),
  .ser_vld_o (ser_vld_o),
  .done_o    (done_o),
  .ready_o   (ready_o)
);

// File: tb/sim_p2s_parity_tx.sv
module sim_p2s_parity_tx;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         ser_o, ser_vld_o, done_o, ready_o;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  p2s_parity_tx #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i),
    .ser_o(ser_o), .ser_vld_o(ser_vld_o), .done_o(done_o), .ready_o(ready_o)
  );

  function automatic logic exp_bit(input logic [W-1:0] w, input int k);
    if (k < W - 1) return w[k];
    return ^w[W-2:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // raise load once ready, return at the negedge after the accepting edge
  task automatic start(input logic [W-1:0] w);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    load_i = 1'b1;
    word_i = w;
    @(negedge clk);
    load_i = 1'b0;
    chk(ready_o == 1'b0, "R2 busy after accept", ready_o, 0);
    chk(ser_vld_o == 1'b0, "R2 no bit yet", ser_vld_o, 0);
  endtask

  task automatic collect(input logic [W-1:0] w, input bit poke, input bit chain,
                         input logic [W-1:0] nw);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      chk(ser_vld_o == 1'b1, "R5 valid during word", ser_vld_o, 1);
      if (k < W - 1)
        chk(ser_o == exp_bit(w, k), "R3 data bit", ser_o, exp_bit(w, k));
      else
        chk(ser_o == exp_bit(w, k), "R4 parity bit", ser_o, exp_bit(w, k));
      if (poke && k == 3) begin
        load_i = 1'b1;
        word_i = ~w;
      end
      if (poke && k == 4) load_i = 1'b0;
      if (k == W - 1) begin
        chk(ready_o == 1'b1, "R6 ready with last bit", ready_o, 1);
        if (chain) begin
          load_i = 1'b1;
          word_i = nw;
        end
      end
    end
    @(negedge clk);
    load_i = 1'b0;
    chk(done_o == 1'b1, "R6 done after last bit", done_o, 1);
    chk(ser_vld_o == 1'b0, "R5 valid ends after eight", ser_vld_o, 0);
    chk(ser_o == 1'b0, "R9 line low when idle", ser_o, 0);
    if (chain) begin
      chk(ready_o == 1'b0, "R8 chained load accepted", ready_o, 0);
    end else begin
      @(negedge clk);
      chk(done_o == 1'b0, "R6 done one cycle", done_o, 1'b0);
      @(negedge clk);
      chk(ser_vld_o == 1'b0, "R7 no extra word", ser_vld_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(ser_o == 1'b0, "R1 ser_o reset", ser_o, 0);
    chk(ser_vld_o == 1'b0, "R1 valid reset", ser_vld_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    chk(ready_o == 1'b1, "R1 ready reset", ready_o, 1);

    // directed corners; 8'h80 shows input bit 7 is ignored (R4)
    start(8'h00); collect(8'h00, 1'b0, 1'b0, '0);
    start(8'h7F); collect(8'h7F, 1'b0, 1'b0, '0);
    start(8'h80); collect(8'h80, 1'b0, 1'b0, '0);
    start(8'h01); collect(8'h01, 1'b0, 1'b0, '0);
    start(8'hFE); collect(8'hFE, 1'b0, 1'b0, '0);

    // R7: load raised in the middle of a shift
    start(8'h35); collect(8'h35, 1'b1, 1'b0, '0);

    // R8: odd-parity word chained straight into the next
    start(8'h01); collect(8'h01, 1'b0, 1'b1, 8'h02);
    collect(8'h02, 1'b0, 1'b1, 8'h00);
    collect(8'h00, 1'b0, 1'b0, '0);

    // random words, random bit 7, random poke and chaining
    void'($urandom(32'd20240611));
    begin
      logic [W-1:0] cur;
      cur = W'($urandom);
      start(cur);
      for (int n = 0; n < 60; n++) begin
        logic [W-1:0] nxt;
        bit           ch;
        bit           pk;
        nxt = W'($urandom);
        ch  = ($urandom % 2) == 1;
        pk  = ($urandom % 4) == 0;
        collect(cur, pk, ch, nxt);
        if (!ch) start(nxt);
        cur = nxt;
      end
      collect(cur, 1'b0, 1'b0, '0);
    end

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule